// File: doc/BRIEF.md
# Output Port Selector with Read Time-Out Flush

This block sits between a packet ingress controller and a set of output queues. When the ingress side flags that a new header is present, the block captures the two-bit destination code and keeps it until the next header. While that code is held, the block routes the single write strobe to the matching queue and returns that queue's full flag to the ingress side. Codes that name no queue select nothing.

On the egress side it turns each queue's empty flag into a data-available indication for the receiver. It also guards every port with its own time-out counter. If a port shows data for a fixed number of clock cycles and its receiver never reads, the block raises a one-cycle flush strobe for that queue, so a stalled receiver cannot hold stale packets forever.

All state is cleared by a synchronous active-low reset.

Top module: `port_steer_sync`

## Requirements
- R1: The destination code is captured on a rising edge where `hdr_detect` is high, and stays in force, regardless of `dest_code`, until the next such edge.
- R2: `sel_full` equals `q_full[0]`, `q_full[1]` or `q_full[2]` when the held code is 00, 01 or 10, and is 0 when it is 11.
- R3: Each `q_avail[i]` is high exactly when `q_empty[i]` is low.
- R4: `wr_strobe` is the write request routed to the bit whose index equals the held code; at most one bit is ever high, and none when `wr_req` is low.
- R5: With code 11 held, no bit of `wr_strobe` is asserted even when `wr_req` is high.
- R6: `flush[i]` goes high for the cycle after the 30th consecutive rising edge on which `q_avail[i]` is high and `rd_en[i]` is low.
- R7: A flush strobe lasts one cycle; the counter restarts at zero, so a receiver that still does not read causes another strobe 30 edges later.
- R8: An edge with `rd_en[i]` high restarts port i's count from zero.
- R9: An edge with `q_avail[i]` low restarts port i's count from zero.
- R10: Each port's counter runs independently; reading on one port has no effect on the others.
- R11: Reset (`rst_n` low at a rising edge) clears the held code to 00, all counters and all flush strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_detect | input | 1 | Header present; capture `dest_code` |
| dest_code | input | 2 | Destination code of the incoming header |
| wr_req | input | 1 | Write request from the ingress controller |
| rd_en | input | 3 | Per-port read enable from the receivers |
| q_full | input | 3 | Per-queue full flags |
| q_empty | input | 3 | Per-queue empty flags |
| sel_full | output | 1 | Full flag of the selected queue |
| q_avail | output | 3 | Per-port data-available indication |
| wr_strobe | output | 3 | One-hot write enable to the queues |
| flush | output | 3 | Per-queue one-cycle flush strobe |

## Verification
The bench builds the block with its defaults: three ports, a two-bit code and a 30-cycle time-out. Using the full time-out, rather than a shortened one, lets the bench land exactly on edge 29 versus edge 30 for the strobe and observe the repeat strobe after another 30 edges. The two-bit code with three ports keeps the unused code 11 reachable, so the select-nothing path for both write and full steering is exercised.

// File: rtl/pss_pkg.sv
package pss_pkg;

    localparam int DEF_PORTS   = 3;
    localparam int DEF_CODE_W  = 2;
    localparam int DEF_TIMEOUT = 30;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic avail;
        logic rd;
    } port_obs_t;

    function automatic logic wd_stall(input port_obs_t o);
        return o.avail && !o.rd;
    endfunction

endpackage

// File: rtl/pss_code_reg.sv
module pss_code_reg #(
    parameter int CODE_W = pss_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (capture)
            code_q <= code_in;
    end

endmodule

// File: rtl/pss_steer.sv
module pss_steer #(
    parameter int PORTS  = pss_pkg::DEF_PORTS,
    parameter int CODE_W = pss_pkg::DEF_CODE_W
) (
    input  logic [CODE_W-1:0] code_q,
    input  logic              wr_req,
    input  logic [PORTS-1:0]  q_full,
    output logic [PORTS-1:0]  wr_strobe,
    output logic              sel_full
);

    logic [PORTS-1:0] hit;

    for (genvar i = 0; i < PORTS; i++) begin : g_dec
        assign hit[i]       = (code_q == CODE_W'(i));
        assign wr_strobe[i] = wr_req && hit[i];
    end

    assign sel_full = |(hit & q_full);

endmodule

// File: rtl/pss_watchdog.sv
module pss_watchdog #(
    parameter int TIMEOUT = pss_pkg::DEF_TIMEOUT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic avail,
    input  logic rd,
    output logic flush
);
    import pss_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    port_obs_t        obs;
    wd_state_e        st;
    logic [CNT_W-1:0] cnt;

    assign obs.avail = avail;
    assign obs.rd    = rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            st  <= WD_IDLE;
        end else if (!wd_stall(obs)) begin
            cnt <= '0;
            st  <= WD_IDLE;
        end else if (cnt == LAST) begin
            cnt <= '0;
            st  <= WD_FIRE;
        end else begin
            cnt <= cnt + 1'b1;
            st  <= WD_COUNT;
        end
    end

    assign flush = (st == WD_FIRE);

endmodule

// File: rtl/port_steer_sync.sv
module port_steer_sync #(
    parameter int PORTS   = pss_pkg::DEF_PORTS,
    parameter int CODE_W  = pss_pkg::DEF_CODE_W,
    parameter int TIMEOUT = pss_pkg::DEF_TIMEOUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_detect,
    input  logic [CODE_W-1:0] dest_code,
    input  logic              wr_req,
    input  logic [PORTS-1:0]  rd_en,
    input  logic [PORTS-1:0]  q_full,
    input  logic [PORTS-1:0]  q_empty,
    output logic              sel_full,
    output logic [PORTS-1:0]  q_avail,
    output logic [PORTS-1:0]  wr_strobe,
    output logic [PORTS-1:0]  flush
);

    logic [CODE_W-1:0] code_q;

    pss_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (hdr_detect),
        .code_in (dest_code),
        .code_q  (code_q)
    );

    pss_steer #(.PORTS(PORTS), .CODE_W(CODE_W)) u_steer (
        .code_q    (code_q),
        .wr_req    (wr_req),
        .q_full    (q_full),
        .wr_strobe (wr_strobe),
        .sel_full  (sel_full)
    );

    assign q_avail = ~q_empty;

    for (genvar i = 0; i < PORTS; i++) begin : g_wd
        pss_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
            .clk   (clk),
            .rst_n (rst_n),
            .avail (q_avail[i]),
            .rd    (rd_en[i]),
            .flush (flush[i])
        );
    end

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int PORTS  = 3,
    parameter int CODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_detect,
    input logic              wr_req,
    input logic [PORTS-1:0]  rd_en,
    input logic [PORTS-1:0]  q_avail,
    input logic              sel_full,
    input logic [PORTS-1:0]  wr_strobe,
    input logic [PORTS-1:0]  flush
);

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe));  // R4

    AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_strobe) |-> wr_req);  // R4

    AST_UNUSED_CODE_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !(|wr_strobe)) |-> !sel_full);  // R5

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hdr_detect) && wr_req && $past(wr_req)) |-> (wr_strobe == $past(wr_strobe)));  // R1

    for (genvar i = 0; i < PORTS; i++) begin : g_port
        AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            flush[i] |=> !flush[i]);  // R7

        AST_FLUSH_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flush[i]) |-> $past(q_avail[i] && !rd_en[i]));  // R6
    end

endmodule

bind port_steer_sync pss_checker #(.PORTS(PORTS), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_detect (hdr_detect),
    .wr_req     (wr_req),
    .rd_en      (rd_en),
    .q_avail    (q_avail),
    .sel_full   (sel_full),
    .wr_strobe  (wr_strobe),
    .flush      (flush)
);

// File: tb/sim_port_steer_sync.sv
`timescale 1ns/1ps
module sim_port_steer_sync;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hdr_detect;
    logic [1:0] dest_code;
    logic       wr_req;
    logic [2:0] rd_en;
    logic [2:0] q_full;
    logic [2:0] q_empty;
    logic       sel_full;
    logic [2:0] q_avail;
    logic [2:0] wr_strobe;
    logic [2:0] flush;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_steer_sync u0 (
        .clk(clk), .rst_n(rst_n), .hdr_detect(hdr_detect), .dest_code(dest_code),
        .wr_req(wr_req), .rd_en(rd_en), .q_full(q_full), .q_empty(q_empty),
        .sel_full(sel_full), .q_avail(q_avail), .wr_strobe(wr_strobe), .flush(flush)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        hdr_detect = 0; dest_code = 0; wr_req = 0;
        rd_en = 0; q_full = 0; q_empty = 3'b111;
        rst_n = 0;
        tick(2);
        rst_n = 1;
        #1;
    endtask

    task automatic latch_code(input logic [1:0] c);
        hdr_detect = 1; dest_code = c;
        tick();
        hdr_detect = 0; dest_code = ~c;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R11", "flush after reset", flush, 0);
        check("R11", "strobe idle", wr_strobe, 0);
        wr_req = 1; #1;
        check("R11", "code cleared to 00", wr_strobe, 3'b001);
        wr_req = 0;
    endtask

    task automatic t_steer();
        do_reset();
        for (int c = 0; c < 4; c++) begin
            latch_code(c[1:0]);
            wr_req = 1; q_full = 3'b000; #1;
            if (c < 3) check("R4", "strobe routed", wr_strobe, 1 << c);
            else       check("R5", "unused code strobe", wr_strobe, 0);
            q_full = 3'b111; #1;
            check("R2", "sel_full all full", sel_full, (c < 3) ? 1 : 0);
            q_full = ~(3'(1) << (c % 3)); #1;
            check("R2", "sel_full others full", sel_full, 0);
            wr_req = 0; #1;
            check("R4", "no request no strobe", wr_strobe, 0);
        end
        q_full = 0;
    endtask

    task automatic t_hold();
        do_reset();
        latch_code(2'b01);
        wr_req = 1;
        tick(3);
        check("R1", "code held while pins change", wr_strobe, 3'b010);
        latch_code(2'b10);
        check("R1", "new header recaptures", wr_strobe, 3'b100);
        wr_req = 0;
    endtask

    task automatic t_avail();
        do_reset();
        q_empty = 3'b101; #1;
        check("R3", "avail pattern a", q_avail, 3'b010);
        q_empty = 3'b010; #1;
        check("R3", "avail pattern b", q_avail, 3'b101);
        q_empty = 3'b111;
    endtask

    task automatic t_timeout();
        do_reset();
        q_empty = 3'b110;
        tick(29);
        check("R6", "no flush at 29", flush, 0);
        tick();
        check("R6", "flush at 30", flush, 3'b001);
        tick();
        check("R7", "flush one cycle", flush, 0);
        tick(28);
        check("R7", "no repeat yet", flush, 0);
        tick();
        check("R7", "repeat after 30", flush, 3'b001);
        q_empty = 3'b111;
    endtask

    task automatic t_read_restart();
        do_reset();
        q_empty = 3'b101;
        tick(20);
        rd_en = 3'b010; tick(); rd_en = 0;
        tick(29);
        check("R8", "read restarted count", flush, 0);
        tick();
        check("R8", "flush 30 after read", flush, 3'b010);
        q_empty = 3'b111;
    endtask

    task automatic t_avail_restart();
        do_reset();
        q_empty = 3'b011;
        tick(25);
        q_empty = 3'b111; tick(); q_empty = 3'b011;
        tick(29);
        check("R9", "empty restarted count", flush, 0);
        tick();
        check("R9", "flush 30 after empty", flush, 3'b100);
        q_empty = 3'b111;
    endtask

    task automatic t_independent();
        do_reset();
        q_empty = 3'b010;
        rd_en = 3'b001;
        tick(30);
        check("R10", "only unread port flushes", flush, 3'b100);
        rd_en = 0; q_empty = 3'b111;
    endtask

    task automatic t_reset_mid();
        do_reset();
        q_empty = 3'b110;
        tick(20);
        rst_n = 0; tick(); rst_n = 1;
        check("R11", "no flush in reset", flush, 0);
        tick(29);
        check("R11", "counter cleared by reset", flush, 0);
        tick();
        check("R11", "flush 30 after reset", flush, 3'b001);
        q_empty = 3'b111;
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_steer();
        t_hold();
        t_avail();
        t_timeout();
        t_read_restart();
        t_avail_restart();
        t_independent();
        t_reset_mid();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule